// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block turns the data operand of an 8-bit microcontroller instruction into a target memory space and an address, or into a literal value. The decoder supplies an addressing-mode code, one or two operand bytes from the instruction, and two flags. One flag says whether the operand is the destination. The other says whether the opposite operand is 16 bits wide. Context comes from the register-bank select, the current R0 and R1 contents and the 16-bit data pointer. The block reports one of four spaces: internal RAM, special-function registers, external data, or immediate. It also gives a 16-bit address, a 16-bit immediate value and a valid flag.

The resolution is combinational. A parameter adds one register stage on the outputs for timing closure. Illegal combinations are flagged and their outputs forced to zero, so that later stages never act on a partly resolved operand.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 0 (working register) gives space code 0 (internal RAM) and address bank×8+n. Here n is bits [2:0] of the operand byte and bank is the 2-bit bank select, so the address falls in 00h–1Fh.
- R2: Mode code 1 (direct) gives the operand byte, zero-extended, as the address. Bit 7 clear selects space code 0 (internal RAM) and bit 7 set selects space code 1 (special-function registers).
- R3: Mode code 2 (8-bit pointer) uses bits [2:0] of the operand byte to pick the pointer: value 0 picks R0 and value 1 picks R1. The address is the pointer contents zero-extended, and the space is always code 0. Any other pointer value is invalid.
- R4: Mode code 3 (data-pointer indirect) gives the 16-bit data pointer as the address, with space code 2 (external data).
- R5: Mode code 4 (8-bit immediate) gives space code 3, address 0 and the operand byte zero-extended as the immediate. It is valid only as a source and only when the opposite operand is 8 bits wide.
- R6: Mode code 5 (16-bit immediate) gives space code 3, address 0 and the immediate {second byte, operand byte}. It is valid only as a source and only when the opposite operand is 16 bits wide.
- R7: An immediate mode used as a destination is invalid.
- R8: Mode codes 6 and 7 are invalid. Every invalid case drives valid low and forces address, immediate and space to zero.
- R9: Every valid non-immediate mode drives the immediate output to zero. The opposite-width flag has no effect in these modes.
- R10: With the registered option, each output equals the combinational result of the previous clock cycle, and an active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rstN | input | 1 | Active-low reset |
| modeIn | input | 3 | Addressing-mode code |
| isDest | input | 1 | Operand is the destination |
| dstWide | input | 1 | Opposite operand is 16 bits wide |
| bankSel | input | 2 | Register-bank select |
| opByte | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte (upper byte of a 16-bit immediate) |
| r0Val | input | 8 | Current R0 contents |
| r1Val | input | 8 | Current R1 contents |
| dptrVal | input | 16 | Data pointer |
| spaceOut | output | 2 | 0 internal RAM, 1 SFR, 2 external data, 3 immediate |
| addrOut | output | 16 | Resolved address |
| immOut | output | 16 | Immediate value |
| validOut | output | 1 | Operand legal |

## Verification
Two legality rules can act in the same cycle on an immediate operand: the width-match rule and the no-immediate-destination rule. The sweep drives both immediate modes with all four combinations of isDest and dstWide, for every operand byte and bank. The bench expects valid only for the source case whose width matches, and expects all-zero outputs in the other three cases. Each vector is also checked on a second instance with the registered option, one edge later, so that zeroing and capture coincide.

// File: rtl/opres_pkg.sv
package opres_pkg;
  typedef enum logic [1:0] {SP_IRAM = 2'd0, SP_SFR = 2'd1, SP_XDATA = 2'd2, SP_IMM = 2'd3} space_e;
  typedef enum logic [2:0] {
    M_REG = 3'd0, M_DIR = 3'd1, M_IND8 = 3'd2, M_INDDP = 3'd3,
    M_IMM8 = 3'd4, M_IMM16 = 3'd5, M_RSV6 = 3'd6, M_RSV7 = 3'd7
  } mode_e;
  typedef struct packed {
    logic selReg;
    logic selDir;
    logic selPtr0;
    logic selPtr1;
    logic selDptr;
    logic selImm8;
    logic selImm16;
  } strobe_t;
endpackage

// File: rtl/opres_ctrl.sv
module opres_ctrl
  import opres_pkg::*;
#(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     modeIn,
  input  logic           isDest,
  input  logic           dstWide,
  input  logic [PSW-1:0] ptrSel,
  output strobe_t        strobes
);
  mode_e mode;
  assign mode = mode_e'(modeIn);

  always_comb begin
    strobes = '0;
    unique case (mode)
      M_REG:   strobes.selReg   = 1'b1;
      M_DIR:   strobes.selDir   = 1'b1;
      M_IND8: begin
        strobes.selPtr0 = (ptrSel == PSW'(0));
        strobes.selPtr1 = (ptrSel == PSW'(1));
      end
      M_INDDP: strobes.selDptr  = 1'b1;
      M_IMM8:  strobes.selImm8  = !isDest && !dstWide;
      M_IMM16: strobes.selImm16 = !isDest && dstWide;
      default: strobes = '0;
    endcase
  end

  // R8: the strobes are one-hot or empty, never two at once
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  // R7: an immediate used as a destination raises no strobe
  a_r7_imm_dest: assert property (@(posedge clk) disable iff (!rstN)
    (isDest && (modeIn == 3'd4 || modeIn == 3'd5)) |-> (strobes == '0));
  // R3: pointer values other than 0 and 1 raise no strobe
  a_r3_bad_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd2 && ptrSel > PSW'(1)) |-> (strobes == '0));
endmodule

// File: rtl/opres_dp.sv
module opres_dp
  import opres_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PW    = 16,
  parameter int NREG  = 8,
  parameter int NBANK = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobes,
  input  logic [$clog2(NBANK)-1:0] bankSel,
  input  logic [DW-1:0]  opByte,
  input  logic [DW-1:0]  opHi,
  input  logic [DW-1:0]  r0Val,
  input  logic [DW-1:0]  r1Val,
  input  logic [PW-1:0]  dptrVal,
  output logic [1:0]     spaceOut,
  output logic [PW-1:0]  addrOut,
  output logic [PW-1:0]  immOut,
  output logic           validOut
);
  localparam int RW = $clog2(NREG);
  localparam int BW = $clog2(NBANK);
  localparam logic [PW-1:0] REG_TOP = PW'(NREG * NBANK);

  space_e space;

  always_comb begin
    space   = SP_IRAM;
    addrOut = '0;
    immOut  = '0;
    if (strobes.selReg) begin
      addrOut = PW'({bankSel, opByte[RW-1:0]});
    end
    if (strobes.selDir) begin
      addrOut = PW'(opByte);
      space   = opByte[DW-1] ? SP_SFR : SP_IRAM;
    end
    if (strobes.selPtr0) addrOut = PW'(r0Val);
    if (strobes.selPtr1) addrOut = PW'(r1Val);
    if (strobes.selDptr) begin
      addrOut = dptrVal;
      space   = SP_XDATA;
    end
    if (strobes.selImm8) begin
      immOut = PW'(opByte);
      space  = SP_IMM;
    end
    if (strobes.selImm16) begin
      immOut = PW'({opHi, opByte});
      space  = SP_IMM;
    end
  end

  assign spaceOut = space;
  assign validOut = |strobes;

  // R1: register operands stay inside the bank area
  a_r1_reg_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selReg |-> (addrOut < REG_TOP && spaceOut == 2'd0));
  // R2: direct space follows the top address bit
  a_r2_dir_space: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selDir |-> (spaceOut == {1'b0, opByte[DW-1]}));
  // R3: 8-bit pointers never reach SFR space or high addresses
  a_r3_ptr_iram: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selPtr0 || strobes.selPtr1) |-> (spaceOut == 2'd0 && addrOut[PW-1:DW] == '0));
  // R5, R6: immediates carry no address
  a_r5_imm_noaddr: assert property (@(posedge clk) disable iff (!rstN)
    (spaceOut == 2'd3) |-> (addrOut == '0 && validOut));
  // R8: invalid operands are fully zeroed
  a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (addrOut == '0 && immOut == '0 && spaceOut == 2'd0));
  // R9: non-immediate operands leave the immediate at zero
  a_r9_imm_zero: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && spaceOut != 2'd3) |-> (immOut == '0));
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opres_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PW      = 16,
  parameter int NREG    = 8,
  parameter int NBANK   = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    modeIn,
  input  logic          isDest,
  input  logic          dstWide,
  input  logic [$clog2(NBANK)-1:0] bankSel,
  input  logic [DW-1:0] opByte,
  input  logic [DW-1:0] opHi,
  input  logic [DW-1:0] r0Val,
  input  logic [DW-1:0] r1Val,
  input  logic [PW-1:0] dptrVal,
  output logic [1:0]    spaceOut,
  output logic [PW-1:0] addrOut,
  output logic [PW-1:0] immOut,
  output logic          validOut
);
  localparam int PSW = $clog2(NREG);

  strobe_t       strobes;
  logic [1:0]    dpSpace;
  logic [PW-1:0] dpAddr;
  logic [PW-1:0] dpImm;
  logic          dpValid;

  opres_ctrl #(.PSW(PSW)) uCtrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .isDest(isDest),
    .dstWide(dstWide), .ptrSel(opByte[PSW-1:0]), .strobes(strobes)
  );

  opres_dp #(.DW(DW), .PW(PW), .NREG(NREG), .NBANK(NBANK)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bankSel(bankSel),
    .opByte(opByte), .opHi(opHi), .r0Val(r0Val), .r1Val(r1Val),
    .dptrVal(dptrVal), .spaceOut(dpSpace), .addrOut(dpAddr),
    .immOut(dpImm), .validOut(dpValid)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          spaceOut <= '0;
          addrOut  <= '0;
          immOut   <= '0;
          validOut <= 1'b0;
        end else begin
          spaceOut <= dpSpace;
          addrOut  <= dpAddr;
          immOut   <= dpImm;
          validOut <= dpValid;
        end
      end
      // R10: registered outputs trail the resolved value by one cycle
      a_r10_delay: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (addrOut == $past(dpAddr) && validOut == $past(dpValid)));
    end else begin : gComb
      assign spaceOut = dpSpace;
      assign addrOut  = dpAddr;
      assign immOut   = dpImm;
      assign validOut = dpValid;
    end
  endgenerate
endmodule

// File: tb/sim_opnd_resolver.sv
module sim_opnd_resolver;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeIn = '0;
  logic isDest = 1'b0, dstWide = 1'b0;
  logic [1:0] bankSel = '0;
  logic [7:0] opByte = '0, opHi = '0, r0Val = '0, r1Val = '0;
  logic [15:0] dptrVal = '0;
  logic [1:0] sp0, sp1;
  logic [15:0] ad0, ad1, im0, im1;
  logic v0, v1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opnd_resolver u0 (.clk, .rstN, .modeIn, .isDest, .dstWide, .bankSel, .opByte,
    .opHi, .r0Val, .r1Val, .dptrVal, .spaceOut(sp0), .addrOut(ad0), .immOut(im0), .validOut(v0));
  opnd_resolver #(.REG_OUT(1'b1)) u1 (.clk, .rstN, .modeIn, .isDest, .dstWide, .bankSel, .opByte,
    .opHi, .r0Val, .r1Val, .dptrVal, .spaceOut(sp1), .addrOut(ad1), .immOut(im1), .validOut(v1));

  logic [1:0] eSp; logic [15:0] eAd, eIm; logic eV;

  function automatic string tagOf(input logic [2:0] m, input logic d);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return d ? "R7" : "R5";
      3'd5: return d ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic model();
    eV = 1'b1; eSp = 2'd0; eAd = '0; eIm = '0;
    case (modeIn)
      3'd0: eAd = 16'(bankSel) * 16'd8 + 16'(opByte[2:0]);
      3'd1: begin eAd = 16'(opByte); eSp = opByte[7] ? 2'd1 : 2'd0; end
      3'd2: if (opByte[2:0] == 3'd0) eAd = 16'(r0Val);
            else if (opByte[2:0] == 3'd1) eAd = 16'(r1Val);
            else eV = 1'b0;
      3'd3: begin eAd = dptrVal; eSp = 2'd2; end
      3'd4: begin eV = !isDest && !dstWide; eIm = 16'(opByte); eSp = 2'd3; end
      3'd5: begin eV = !isDest && dstWide; eIm = {opHi, opByte}; eSp = 2'd3; end
      default: eV = 1'b0;
    endcase
    if (!eV) begin eSp = '0; eAd = '0; eIm = '0; end
  endtask

  task automatic cmp(input string tag, input logic [1:0] s, input logic [15:0] a,
                     input logic [15:0] i, input logic v);
    checks++;
    if (s !== eSp || a !== eAd || i !== eIm || v !== eV) begin
      errors++;
      $display("FAIL %s mode=%0d dest=%0b wide=%0b bank=%0d op=%h: got sp=%0d a=%h i=%h v=%0b exp sp=%0d a=%h i=%h v=%0b",
        tag, modeIn, isDest, dstWide, bankSel, opByte, s, a, i, v, eSp, eAd, eIm, eV);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    eSp = '0; eAd = '0; eIm = '0; eV = 1'b0;
    cmp("R10 reset", sp1, ad1, im1, v1);
    @(negedge clk); rstN = 1'b1;
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 4; b++)
          for (int o = 0; o < 256; o++) begin
            @(negedge clk);
            modeIn = 3'(m); isDest = k[1]; dstWide = k[0]; bankSel = 2'(b);
            opByte = 8'(o); opHi = 8'(o) ^ 8'h5A;
            r0Val = 8'(o * 3 + 7); r1Val = ~8'(o);
            dptrVal = {8'(o + b), ~8'(o)};
            #1;
            model();
            cmp(tagOf(modeIn, isDest), sp0, ad0, im0, v0);
            if (!eV) cmp("R8", sp0, ad0, im0, v0);
            else if (eSp != 2'd3) cmp("R9", sp0, ad0, im0, v0);
            @(posedge clk); #1;
            cmp("R10", sp1, ad1, im1, v1);
          end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule